// File: doc/BRIEF.md
# Dual-Mode Serial Port

This block is a byte-wide serial port with two operating modes, picked by a static mode input. In shift mode (mode 0) it moves 8 bits at a time, least significant bit first, over one bidirectional data pin. The transmit pin carries a shift clock running at one sixteenth of the core clock. A byte write starts a transmit. A receive starts when receive-enable is high and the receive-done flag is clear.

In asynchronous mode (mode 1) it sends and receives full-duplex 10-bit frames: a low start bit, 8 data bits LSB first, and a high stop bit. The bit timing comes from an external 16x oversampling strobe. That strobe is picked from one of two tick inputs: a timer-overflow tick or a separate baud-generator tick. The receiver keeps the sampled stop bit as a ninth received bit. It also flags framing errors and line breaks.

Software sees a parallel write port, a received-byte register, and sticky transmit-done, receive-done, framing-error and break flags. Each flag is cleared by its own clear input. The mode input and the tick select must only change while the port is idle.

Top module: `serport_top`

## Requirements
- R1: After reset, line_tx is 1, line_rx_oe is 0, rx_byte and rx_bit9 are 0, and tx_done, rx_done, frame_err and break_det are all 0.
- R2: In mode 0 (mode_sel=0) a transmit puts the 8 bits of tx_byte on line_rx_o, LSB first, with line_rx_oe high. line_tx carries the shift clock with a period of 16 core clocks: 8 low, then 8 high. Data changes only on the falling clock edge, so it is stable at each rising edge.
- R3: In mode 0, tx_done is seen high 129 clocks after the clock edge that takes tx_wr. That is 128 clocks for the 8 bit periods plus one flag register.
- R4: In mode 0 a receive runs only while rx_en=1 and rx_done=0. With rx_en=0, or with rx_done still set, line_tx stays high. The receive samples line_rx_i on each rising shift-clock edge, LSB first, loads rx_byte, leaves rx_bit9 unchanged and sets rx_done.
- R5: In mode 1 (mode_sel=1) a transmit sends a 10-bit frame on line_tx: a start bit 0, the 8 data bits LSB first, then a stop bit 1. Each bit lasts 16 selected ticks. tx_done is set after the stop bit.
- R6: tick_sel=0 takes the bit timing from tick_timer, and tick_sel=1 takes it from tick_bgen. The tick that is not selected has no effect.
- R7: In mode 1 with rx_en=1, a falling edge on line_rx_i starts a frame. Each bit is sampled 8 ticks into its period. At the stop-bit sample, rx_byte gets the data, rx_bit9 gets the stop-bit value, and rx_done is set. With rx_en=0 no frame is received.
- R8: A start bit that reads 1 at its mid-bit sample is dropped. No rx_done follows, and the next real frame is still received.
- R9: A stop bit sampled as 0 sets frame_err.
- R10: A frame whose start bit, 8 data bits and stop bit are all 0 sets break_det, together with frame_err.
- R11: tx_done, rx_done, frame_err and break_det stay set until their clear input (tx_done_clr, rx_done_clr, err_clr) is pulsed. A clear sets them back to 0.
- R12: A tx_wr that arrives while a transmit is running is ignored. No extra frame is sent.
- R13: When idle, line_tx is high in both modes: the idle line level in mode 1, and the idle level of the shift clock in mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 1 | 0 = shift mode, 1 = asynchronous mode |
| tick_sel | input | 1 | 0 = timer tick, 1 = baud-generator tick |
| tick_timer | input | 1 | Timer-overflow 16x strobe |
| tick_bgen | input | 1 | Baud-generator 16x strobe |
| tx_wr | input | 1 | Write strobe that starts a transmit |
| tx_byte | input | 8 | Byte to transmit |
| rx_en | input | 1 | Receive enable |
| tx_done_clr | input | 1 | Clears tx_done |
| rx_done_clr | input | 1 | Clears rx_done |
| err_clr | input | 1 | Clears frame_err and break_det |
| line_rx_i | input | 1 | Receive / shift-data pin, input side |
| line_rx_o | output | 1 | Shift-data pin, output side |
| line_rx_oe | output | 1 | Output enable for the shift-data pin |
| line_tx | output | 1 | Async transmit data, or the shift clock in mode 0 |
| rx_byte | output | 8 | Last received byte |
| rx_bit9 | output | 1 | Stop bit of the last async frame |
| tx_done | output | 1 | Sticky transmit-complete flag |
| rx_done | output | 1 | Sticky receive-complete flag |
| frame_err | output | 1 | Sticky framing-error flag |
| break_det | output | 1 | Sticky break flag |

## Verification
The bench counts the exact cycle at which mode-0 tx_done appears and checks the shift-clock period and duty cycle. A counter that is one off, or a clock that rises at the wrong phase, would move the flag or garble the bits. A mode-0 receive is held back by a set rx_done, and rx_en is left high while this is checked. A design that restarted on the done cycle would toggle the shift clock there.

On the async side, the bench sends a glitch that looks like a start bit, a frame with a zero stop bit, and an all-zero break. A receiver that did not recheck the start bit would report a phantom byte. One that did not test the stop bit would miss frame_err or break_det. A second write in the middle of a frame is also sent, and a transmitter that accepted it would put an extra frame on the line. Frames run at both tick rates, so a design that ignores tick_sel loses bit alignment.

// File: rtl/serport_pkg.sv
// Shared types and constants for the dual-mode serial port.
// Assumes: one frame carries exactly one start bit and one stop bit around the data.
package serport_pkg;

    // Operating mode selected by the mode_sel pin.
    typedef enum logic {
        MODE_SHIFT = 1'b0,
        MODE_ASYNC = 1'b1
    } sport_mode_e;

    // Framing overhead of an asynchronous frame (start + stop).
    localparam int FRAME_EXTRA = 2;

endpackage

// File: rtl/serport_shift.sv
// Synchronous shift engine (mode 0). Each transfer shifts DATA_W bits LSB first,
// one bit per DIV core clocks. The shift clock is low for the first half of each bit
// and high for the second half. Transmit data changes as the clock falls; receive data
// is captured as the clock rises.
// Assumes: start_tx and start_rx are only honoured while idle; rx_line is already synchronised.
module serport_shift #(
    parameter int DATA_W = 8,
    parameter int DIV    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_tx,
    input  logic              start_rx,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_line,
    output logic              drive_en,
    output logic              data_out,
    output logic              sclk,
    output logic              busy,
    output logic              done_tx,
    output logic              done_rx,
    output logic [DATA_W-1:0] rx_data
);
    localparam int PH_W  = $clog2(DIV);
    localparam int BIT_W = $clog2(DATA_W);
    localparam int HALF  = DIV / 2;

    logic [PH_W-1:0]   ph;
    logic [BIT_W-1:0]  bit_idx;
    logic              is_tx;
    logic [DATA_W-1:0] shreg;

    // Sequence phase, bit count, shift clock and the shared shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= '0;
            bit_idx <= '0;
            is_tx   <= 1'b0;
            shreg   <= '0;
            sclk    <= 1'b1;
            busy    <= 1'b0;
            done_tx <= 1'b0;
            done_rx <= 1'b0;
        end else begin
            done_tx <= 1'b0;
            done_rx <= 1'b0;
            if (!busy) begin
                if (start_tx) begin
                    busy    <= 1'b1;
                    is_tx   <= 1'b1;
                    shreg   <= tx_data;
                    ph      <= '0;
                    bit_idx <= '0;
                    sclk    <= 1'b0;
                end else if (start_rx) begin
                    busy    <= 1'b1;
                    is_tx   <= 1'b0;
                    ph      <= '0;
                    bit_idx <= '0;
                    sclk    <= 1'b0;
                end
            end else begin
                ph <= (ph == PH_W'(DIV - 1)) ? '0 : ph + 1'b1;
                if (ph == PH_W'(HALF - 1)) begin
                    sclk <= 1'b1;
                    if (!is_tx) shreg <= {rx_line, shreg[DATA_W-1:1]};
                end else if (ph == PH_W'(DIV - 1)) begin
                    if (bit_idx == BIT_W'(DATA_W - 1)) begin
                        busy    <= 1'b0;
                        done_tx <= is_tx;
                        done_rx <= !is_tx;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        sclk    <= 1'b0;
                        if (is_tx) shreg <= {1'b0, shreg[DATA_W-1:1]};
                    end
                end
            end
        end
    end

    // Pin-side views of the engine.
    always_comb begin
        drive_en = busy && is_tx;
        data_out = shreg[0];
        rx_data  = shreg;
    end

    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk); // R13
    AST_DATA_STABLE_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && sclk && $past(sclk) && $past(busy)) |-> $stable(data_out)); // R2

endmodule

// File: rtl/serport_async_tx.sv
// Asynchronous frame transmitter (mode 1). It loads start, data and stop bits into a
// frame register and moves one bit out every OVS ticks. Ones are shifted in behind,
// so the line rests high.
// Assumes: tick is a one-cycle strobe at OVS times the bit rate.
module serport_async_tx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [DATA_W-1:0] data,
    output logic              line,
    output logic              busy,
    output logic              done
);
    import serport_pkg::*;
    localparam int FRAME_W = DATA_W + FRAME_EXTRA;
    localparam int SUB_W   = $clog2(OVS);
    localparam int CNT_W   = $clog2(FRAME_W);

    logic [FRAME_W-1:0] frame;
    logic [SUB_W-1:0]   sub;
    logic [CNT_W-1:0]   bit_cnt;

    // Frame load, tick-paced shifting and completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame   <= '1;
            sub     <= '0;
            bit_cnt <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    frame   <= {1'b1, data, 1'b0};
                    sub     <= '0;
                    bit_cnt <= '0;
                    busy    <= 1'b1;
                end
            end else if (tick) begin
                if (sub == SUB_W'(OVS - 1)) begin
                    sub   <= '0;
                    frame <= {1'b1, frame[FRAME_W-1:1]};
                    if (bit_cnt == CNT_W'(FRAME_W - 1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end else begin
                    sub <= sub + 1'b1;
                end
            end
        end
    end

    // The serial line is the low end of the frame register.
    assign line = frame[0];

    AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> line); // R13

endmodule

// File: rtl/serport_async_rx.sv
// Asynchronous frame receiver (mode 1). A high-to-low change seen on a tick starts a
// frame. Each bit is sampled OVS/2 ticks into its period. A start bit that reads high
// at its sample is dropped. At the stop-bit sample the byte, the stop value and the
// error conditions are presented with a one-cycle done strobe.
// Assumes: line is synchronised to clk; tick is a one-cycle strobe at OVS times the bit rate.
module serport_async_rx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              enable,
    input  logic              line,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              stop_bit,
    output logic              fe,
    output logic              brk
);
    import serport_pkg::*;
    localparam int FRAME_W = DATA_W + FRAME_EXTRA;
    localparam int SUB_W   = $clog2(OVS);
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam int MID     = OVS / 2 - 1;

    logic              busy;
    logic              line_last;
    logic [SUB_W-1:0]  sub;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;

    // Start detection, mid-bit sampling and frame result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            line_last <= 1'b1;
            sub       <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            done      <= 1'b0;
            data      <= '0;
            stop_bit  <= 1'b0;
            fe        <= 1'b0;
            brk       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) line_last <= line;
            if (!busy) begin
                if (tick && enable && line_last && !line) begin
                    busy    <= 1'b1;
                    sub     <= '0;
                    bit_idx <= '0;
                end
            end else if (tick) begin
                sub <= (sub == SUB_W'(OVS - 1)) ? '0 : sub + 1'b1;
                if (sub == SUB_W'(OVS - 1)) bit_idx <= bit_idx + 1'b1;
                if (sub == SUB_W'(MID)) begin
                    if (bit_idx == '0) begin
                        if (line) busy <= 1'b0;
                    end else if (bit_idx == IDX_W'(FRAME_W - 1)) begin
                        busy     <= 1'b0;
                        done     <= 1'b1;
                        data     <= shreg;
                        stop_bit <= line;
                        fe       <= !line;
                        brk      <= !line && (shreg == '0);
                    end else begin
                        shreg <= {line, shreg[DATA_W-1:1]};
                    end
                end
            end
        end
    end

    AST_RX_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_RX_BREAK_IS_FE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && brk) |-> fe); // R10

endmodule

// File: rtl/serport_top.sv
// Dual-mode serial port top. It selects the bit tick, synchronises the receive pin,
// steers the pins between the shift engine and the async engines, and holds the sticky
// flags and the receive registers.
// Assumes: mode_sel and tick_sel change only while the port is idle.
module serport_top #(
    parameter int DATA_W    = 8,
    parameter int SHIFT_DIV = 16,
    parameter int OVS       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              tick_sel,
    input  logic              tick_timer,
    input  logic              tick_bgen,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              rx_en,
    input  logic              tx_done_clr,
    input  logic              rx_done_clr,
    input  logic              err_clr,
    input  logic              line_rx_i,
    output logic              line_rx_o,
    output logic              line_rx_oe,
    output logic              line_tx,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_bit9,
    output logic              tx_done,
    output logic              rx_done,
    output logic              frame_err,
    output logic              break_det
);
    import serport_pkg::*;

    logic              is_async;
    logic              bit_tick;
    logic              rx_meta, rx_sync;
    logic              sh_busy, sh_sclk, sh_done_tx, sh_done_rx;
    logic [DATA_W-1:0] sh_rx_data;
    logic              at_line, at_busy, at_done;
    logic              ar_done, ar_stop, ar_fe, ar_brk;
    logic [DATA_W-1:0] ar_data;

    // Mode decode and bit-tick source selection.
    always_comb begin
        is_async = (sport_mode_e'(mode_sel) == MODE_ASYNC);
        bit_tick = tick_sel ? tick_bgen : tick_timer;
    end

    // Two-stage synchroniser for the receive pin, resting at the idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_meta <= 1'b1;
            rx_sync <= 1'b1;
        end else begin
            rx_meta <= line_rx_i;
            rx_sync <= rx_meta;
        end
    end

    serport_shift #(.DATA_W(DATA_W), .DIV(SHIFT_DIV)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_tx (!is_async && tx_wr),
        .start_rx (!is_async && rx_en && !rx_done && !sh_done_rx),
        .tx_data  (tx_byte),
        .rx_line  (rx_sync),
        .drive_en (line_rx_oe),
        .data_out (line_rx_o),
        .sclk     (sh_sclk),
        .busy     (sh_busy),
        .done_tx  (sh_done_tx),
        .done_rx  (sh_done_rx),
        .rx_data  (sh_rx_data)
    );

    serport_async_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_atx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (bit_tick),
        .start (is_async && tx_wr),
        .data  (tx_byte),
        .line  (at_line),
        .busy  (at_busy),
        .done  (at_done)
    );

    serport_async_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_arx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (bit_tick),
        .enable   (is_async && rx_en),
        .line     (rx_sync),
        .done     (ar_done),
        .data     (ar_data),
        .stop_bit (ar_stop),
        .fe       (ar_fe),
        .brk      (ar_brk)
    );

    // Transmit pin: shift clock in mode 0, frame data in mode 1.
    assign line_tx = is_async ? at_line : sh_sclk;

    // Sticky flags (a set wins over a clear in the same cycle) and receive registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_done   <= 1'b0;
            rx_done   <= 1'b0;
            frame_err <= 1'b0;
            break_det <= 1'b0;
            rx_byte   <= '0;
            rx_bit9   <= 1'b0;
        end else begin
            if (sh_done_tx || at_done) tx_done <= 1'b1;
            else if (tx_done_clr)      tx_done <= 1'b0;

            if (sh_done_rx || ar_done) rx_done <= 1'b1;
            else if (rx_done_clr)      rx_done <= 1'b0;

            if (ar_done && ar_fe) frame_err <= 1'b1;
            else if (err_clr)     frame_err <= 1'b0;

            if (ar_done && ar_brk) break_det <= 1'b1;
            else if (err_clr)      break_det <= 1'b0;

            if (sh_done_rx) begin
                rx_byte <= sh_rx_data;
            end else if (ar_done) begin
                rx_byte <= ar_data;
                rx_bit9 <= ar_stop;
            end
        end
    end

    AST_OE_ONLY_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        line_rx_oe |-> (sh_busy && !is_async)); // R2
    AST_TX_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !tx_done_clr) |=> tx_done); // R11
    AST_RX_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rx_done_clr) |=> rx_done); // R11
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err && !err_clr) |=> frame_err); // R11
    AST_ASYNC_TX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_async && !at_busy) |-> line_tx); // R13

endmodule

// File: tb/serport_top_bench.sv
// Scoreboard bench: driver tasks queue the expected bytes, and monitors decode the pins
// and flags and compare against the queues.
module serport_top_bench;

    localparam int P_T = 4;   // clocks per timer tick
    localparam int P_B = 3;   // clocks per baud-generator tick

    typedef struct packed {
        logic [7:0] b;
        logic       b9;
        logic       fe;
        logic       brk;
    } rx_exp_t;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       mode_sel = 1'b0, tick_sel = 1'b0;
    logic       tick_timer = 1'b0, tick_bgen = 1'b0;
    logic       tx_wr = 1'b0, rx_en = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       tx_done_clr = 1'b0, rx_done_clr = 1'b0, err_clr = 1'b0;
    logic       line_rx_i = 1'b1;
    logic       line_rx_o, line_rx_oe, line_tx;
    logic [7:0] rx_byte;
    logic       rx_bit9, tx_done, rx_done, frame_err, break_det;

    serport_top u_serport_top (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .tick_sel(tick_sel),
        .tick_timer(tick_timer), .tick_bgen(tick_bgen), .tx_wr(tx_wr), .tx_byte(tx_byte),
        .rx_en(rx_en), .tx_done_clr(tx_done_clr), .rx_done_clr(rx_done_clr),
        .err_clr(err_clr), .line_rx_i(line_rx_i), .line_rx_o(line_rx_o),
        .line_rx_oe(line_rx_oe), .line_tx(line_tx), .rx_byte(rx_byte), .rx_bit9(rx_bit9),
        .tx_done(tx_done), .rx_done(rx_done), .frame_err(frame_err), .break_det(break_det)
    );

    int n_chk = 0, n_fail = 0;
    int cur_p = P_T;
    logic m0_tx_act = 1'b0;
    logic exp_b9 = 1'b0;
    logic [7:0] tx_q[$];
    rx_exp_t rx_q[$];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Tick generators, driven away from the active edge.
    int ct = 0, cb = 0;
    always @(negedge clk) begin
        ct <= (ct == P_T - 1) ? 0 : ct + 1;
        cb <= (cb == P_B - 1) ? 0 : cb + 1;
        tick_timer <= (ct == 0);
        tick_bgen  <= (cb == 0);
    end

    // Mode-0 transmit monitor: captures bits at shift-clock rises, checks the period.
    logic       m0_prev = 1'b1;
    int         m0_nb = 0, m0_gap = 0;
    logic [7:0] m0_got;
    initial begin
        forever begin
            @(negedge clk);
            m0_gap++;
            if (rst_n && !mode_sel && m0_tx_act && !m0_prev && line_tx) begin
                if (m0_nb > 0) check(m0_gap == 16, "R2 clock period", m0_gap, 16);
                check(line_rx_oe == 1'b1, "R2 output enable", line_rx_oe, 1);
                m0_got[m0_nb] = line_rx_o;
                m0_gap = 0;
                m0_nb++;
                if (m0_nb == 8) begin
                    m0_nb = 0;
                    if (tx_q.size() == 0) check(0, "R12 unexpected byte", m0_got, 0);
                    else begin
                        logic [7:0] e;
                        e = tx_q.pop_front();
                        check(m0_got == e, "R2 shifted byte", m0_got, e);
                    end
                end
            end
            m0_prev = line_tx;
        end
    end

    // Mode-1 transmit monitor: decodes frames at mid-bit.
    logic       a_prev = 1'b1;
    logic [9:0] a_frm;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mode_sel && a_prev && !line_tx) begin
                repeat (8 * cur_p - 1) @(negedge clk);
                a_frm[0] = line_tx;
                for (int k = 1; k < 10; k++) begin
                    repeat (16 * cur_p) @(negedge clk);
                    a_frm[k] = line_tx;
                end
                if (tx_q.size() == 0) check(0, "R12 unexpected frame", a_frm, 0);
                else begin
                    logic [7:0] e;
                    e = tx_q.pop_front();
                    check(a_frm == {1'b1, e, 1'b0}, "R5/R6 frame", a_frm, {1'b1, e, 1'b0});
                end
            end
            a_prev = line_tx;
        end
    end

    // Receive monitor: compares registers and flags when rx_done rises.
    logic rxd_prev = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rx_done && !rxd_prev) begin
                if (rx_q.size() == 0) check(0, "R8 unexpected receive", rx_byte, 0);
                else begin
                    rx_exp_t e;
                    e = rx_q.pop_front();
                    check(rx_byte == e.b, "R4/R7 rx_byte", rx_byte, e.b);
                    check(rx_bit9 == e.b9, "R7 rx_bit9", rx_bit9, e.b9);
                    check(frame_err == e.fe, "R9 frame_err", frame_err, e.fe);
                    check(break_det == e.brk, "R10 break_det", break_det, e.brk);
                end
            end
            rxd_prev = rx_done;
        end
    end

    task automatic pulse_clr(input int which);
        @(negedge clk);
        if (which == 0) tx_done_clr = 1'b1;
        if (which == 1) rx_done_clr = 1'b1;
        if (which == 2) err_clr = 1'b1;
        @(negedge clk);
        tx_done_clr = 1'b0; rx_done_clr = 1'b0; err_clr = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        tx_byte = b; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic wait_tx_done;
        int t = 0;
        while (!tx_done && t < 20000) begin @(negedge clk); t++; end
    endtask

    task automatic wait_rx_done;
        int t = 0;
        while (!rx_done && t < 20000) begin @(negedge clk); t++; end
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop_v, input int p);
        logic [9:0] f;
        f = {stop_v, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            line_rx_i = f[i];
            repeat (16 * p - 1) @(negedge clk);
        end
        @(negedge clk);
        line_rx_i = 1'b1;
    endtask

    initial begin : main
        int cnt;
        logic stayed;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(line_tx == 1'b1 && line_rx_oe == 1'b0, "R1 pins", {line_tx, line_rx_oe}, 2'b10);
        check({tx_done, rx_done, frame_err, break_det} == 4'b0, "R1 flags",
              {tx_done, rx_done, frame_err, break_det}, 0);
        check(rx_byte == 8'h00 && rx_bit9 == 1'b0, "R1 rx registers", {rx_bit9, rx_byte}, 0);

        // Mode 0 transmit with exact done timing (R2, R3)
        mode_sel = 1'b0;
        m0_tx_act = 1'b1;
        tx_q.push_back(8'hA5);
        write_byte(8'hA5);
        cnt = 0;
        while (!tx_done && cnt < 1000) begin @(negedge clk); cnt++; end
        check(cnt == 129, "R3 mode-0 tx_done latency", cnt, 129);
        check(line_tx == 1'b1, "R13 shift clock idles high", line_tx, 1);
        repeat (20) @(negedge clk);
        check(tx_done == 1'b1, "R11 tx_done sticky", tx_done, 1);
        pulse_clr(0);
        check(tx_done == 1'b0, "R11 tx_done cleared", tx_done, 0);
        tx_q.push_back(8'h3C);
        write_byte(8'h3C);
        wait_tx_done();
        m0_tx_act = 1'b0;
        pulse_clr(0);

        // Mode 0: no receive while rx_en is low (R4)
        stayed = 1'b1;
        repeat (40) begin @(negedge clk); if (!line_tx) stayed = 1'b0; end
        check(stayed && !rx_done, "R4 rx_en low holds off receive", {stayed, rx_done}, 2'b10);

        // Mode 0 receive (R4)
        rx_q.push_back('{8'h96, exp_b9, 1'b0, 1'b0});
        @(negedge clk);
        rx_en = 1'b1;
        for (int k = 0; k < 8; k++) begin
            while (line_tx !== 1'b0) @(negedge clk);
            line_rx_i = 8'h96 >> k;
            while (line_tx !== 1'b1) @(negedge clk);
        end
        wait_rx_done();
        stayed = 1'b1;
        repeat (40) begin @(negedge clk); if (!line_tx) stayed = 1'b0; end
        check(stayed, "R4 set rx_done blocks a new receive", stayed, 1);
        check(rx_done == 1'b1, "R11 rx_done sticky", rx_done, 1);
        rx_en = 1'b0;
        line_rx_i = 1'b1;
        pulse_clr(1);
        check(rx_done == 1'b0, "R11 rx_done cleared", rx_done, 0);

        // Mode 1 transmit, timer tick, with an ignored mid-frame write (R5, R12)
        mode_sel = 1'b1; tick_sel = 1'b0; cur_p = P_T;
        repeat (4) @(negedge clk);
        check(line_tx == 1'b1, "R13 async line idles high", line_tx, 1);
        tx_q.push_back(8'h5A);
        write_byte(8'h5A);
        repeat (200) @(negedge clk);
        write_byte(8'hFF);
        wait_tx_done();
        repeat (300) @(negedge clk);
        check(tx_q.size() == 0, "R12 busy write ignored", tx_q.size(), 0);
        pulse_clr(0);

        // Mode 1 transmit on the baud-generator tick (R6)
        tick_sel = 1'b1; cur_p = P_B;
        tx_q.push_back(8'hC3);
        write_byte(8'hC3);
        wait_tx_done();
        repeat (100) @(negedge clk);
        check(tx_done == 1'b1, "R5 tx_done after stop", tx_done, 1);
        pulse_clr(0);

        // Mode 1 receive, timer tick, then baud-generator tick (R6, R7)
        rx_en = 1'b1;
        tick_sel = 1'b0; cur_p = P_T;
        exp_b9 = 1'b1;
        rx_q.push_back('{8'h4B, 1'b1, 1'b0, 1'b0});
        send_frame(8'h4B, 1'b1, P_T);
        wait_rx_done();
        pulse_clr(1);
        tick_sel = 1'b1; cur_p = P_B;
        rx_q.push_back('{8'hE1, 1'b1, 1'b0, 1'b0});
        send_frame(8'hE1, 1'b1, P_B);
        wait_rx_done();
        pulse_clr(1);

        // False start (R8), then a real frame
        tick_sel = 1'b0; cur_p = P_T;
        @(negedge clk);
        line_rx_i = 1'b0;
        repeat (3 * P_T) @(negedge clk);
        line_rx_i = 1'b1;
        repeat (800) @(negedge clk);
        check(rx_done == 1'b0, "R8 false start dropped", rx_done, 0);
        rx_q.push_back('{8'h22, 1'b1, 1'b0, 1'b0});
        send_frame(8'h22, 1'b1, P_T);
        wait_rx_done();
        pulse_clr(1);

        // Framing error (R9)
        rx_q.push_back('{8'h81, 1'b0, 1'b1, 1'b0});
        send_frame(8'h81, 1'b0, P_T);
        wait_rx_done();
        repeat (30) @(negedge clk);
        check(frame_err == 1'b1, "R11 frame_err sticky", frame_err, 1);
        pulse_clr(2);
        check(frame_err == 1'b0, "R11 frame_err cleared", frame_err, 0);
        pulse_clr(1);

        // Break (R10)
        rx_q.push_back('{8'h00, 1'b0, 1'b1, 1'b1});
        send_frame(8'h00, 1'b0, P_T);
        wait_rx_done();
        repeat (10) @(negedge clk);
        pulse_clr(2);
        check(break_det == 1'b0, "R11 break_det cleared", break_det, 0);
        pulse_clr(1);

        // Mode 1 receive disabled (R7)
        rx_en = 1'b0;
        send_frame(8'h77, 1'b1, P_T);
        repeat (100) @(negedge clk);
        check(rx_done == 1'b0 && rx_byte == 8'h00, "R7 rx_en low ignores frame",
              {rx_done, rx_byte}, 0);

        check(tx_q.size() == 0 && rx_q.size() == 0, "R5/R7 scoreboard drained",
              tx_q.size() + rx_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: an overrun counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule